// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous burst memory. On any rising clock edge where one of its two start strobes is high (one driven from the processor side, one from the memory-controller side), it captures the external address. On later edges it steps the two lowest address bits through a four-beat burst, and it does so only when the advance input is high. The upper address bits stay fixed for the whole burst. When a burst runs past its fourth beat, the low bits wrap and stay inside the same four-word block.

The ordering input is sampled on the same edge as the start strobe and then holds for the whole burst. It selects linear order, where the low bits count up modulo four from the starting value. It can instead select interleaved order, where the low bits equal the starting low bits XOR the beat number. A caller that does not need bursts can pulse a start strobe on every cycle, and each fresh address appears after one edge with no idle cycle in between. The block also outputs the beat index, which gives the position inside the current burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge clears `cur_addr` and `beat` to zero and sets linear order.
- R2: A rising edge with `start_cpu` or `start_ctl` high (either one, or both) loads `ext_addr` into `cur_addr` and sets `beat` to 0.
- R3: When a start strobe and `adv` are high on the same edge, the load happens and the advance is ignored, so `beat` is 0.
- R4: An edge with `adv` high and no start strobe raises `beat` by one, modulo 4.
- R5: When the burst was loaded with `order_sel` = 0 (linear), `cur_addr[1:0]` equals (starting low bits + `beat`) modulo 4.
- R6: When the burst was loaded with `order_sel` = 1 (interleaved), `cur_addr[1:0]` equals the starting low bits XOR `beat`. `order_sel` is sampled only on load edges, so changing it in the middle of a burst has no effect.
- R7: An edge with no start strobe and `adv` low leaves `cur_addr` and `beat` unchanged.
- R8: Edges without a start strobe never change `cur_addr[AW-1:2]`. Advancing past beat 3 wraps `beat` to 0 and returns the low bits to the starting value.
- R9: Start strobes on consecutive edges load a new address on each edge, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | AW | External word address, captured on a start |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance the burst by one beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order (sampled on start) |
| cur_addr | output | AW | Current internal word address |
| beat | output | 2 | Beat index within the current burst |

## Verification
The assertions assume that every input holds a defined 0 or 1 at each rising edge. They also assume that reset is held for at least one edge before checking starts, since a property only has meaning once the registers have been through a reset edge. The stimulus meets both conditions. The bench drives every input on the falling edge, so values are stable at the rising edge, and it holds reset low for several cycles before any checked cycle. The random draws are biased so that short bursts, long runs of advances past the wrap, held cycles, strobe-with-advance collisions and mid-burst changes of the ordering input all occur often.

// File: rtl/bsq_pkg.sv
// Package: shared types and widths for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bsq_pkg;
    localparam int unsigned LOW_W = 2;   // burst counter width (four beats)

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bsq_load_reg.sv
// Module: bsq_load_reg
// Holds the burst base: upper address bits, starting low bits and the
// ordering mode. All three are captured on a load edge and otherwise held.
// Assumes: load is the OR of the start strobes; synchronous active-low reset.
module bsq_load_reg
    import bsq_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    ext_addr,
    input  order_e           order_in,
    output logic [AW-LOW_W-1:0] base_hi,
    output logic [LOW_W-1:0]    base_lo,
    output order_e           order_q
);
    // Capture the burst base on a load, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            base_lo <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            base_hi <= ext_addr[AW-1:LOW_W];
            base_lo <= ext_addr[LOW_W-1:0];
            order_q <= order_in;
        end
    end

    // R8
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_hi));
endmodule

// File: rtl/bsq_beat_ctr.sv
// Module: bsq_beat_ctr
// Counts beats inside a burst. A load clears it, an advance steps it modulo
// the burst length, and otherwise it holds. Load has priority over advance.
// Assumes: synchronous active-low reset.
module bsq_beat_ctr
    import bsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [LOW_W-1:0] beat
);
    localparam logic [LOW_W-1:0] LAST_BEAT = '1;

    // Clear on load, step on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (load) begin
            beat <= '0;
        end else if (adv) begin
            beat <= beat + 1'b1;
        end
    end

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && adv) |=> (beat == '0));
    // R8
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && beat == LAST_BEAT) |=> (beat == '0));
endmodule

// File: rtl/bsq_order_map.sv
// Module: bsq_order_map
// Maps the starting low bits and the beat index to the current low address
// bits, giving both the linear (modular add) and the interleaved (bitwise
// XOR) orders and picking one with the latched mode.
// Assumes: purely combinational; inputs come from registers.
module bsq_order_map
    import bsq_pkg::*;
(
    input  logic [LOW_W-1:0] base_lo,
    input  logic [LOW_W-1:0] beat,
    input  order_e           order_q,
    output logic [LOW_W-1:0] cur_lo
);
    logic [LOW_W-1:0] lin_lo;
    logic [LOW_W-1:0] ilv_lo;

    // Interleaved order: one XOR per low address bit.
    for (genvar gi = 0; gi < LOW_W; gi++) begin : g_ilv
        assign ilv_lo[gi] = base_lo[gi] ^ beat[gi];
    end

    // Linear order: add the beat index, wrapping inside the block.
    assign lin_lo = base_lo + beat;

    // Pick the order latched with the burst.
    always_comb begin
        cur_lo = (order_q == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer. Either start strobe loads the external address.
// Later advances step the two low bits in linear or interleaved order
// inside a four-word block.
// Assumes: all inputs are synchronous to clk; synchronous active-low reset.
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          start_cpu,
    input  logic          start_ctl,
    input  logic          adv,
    input  logic          order_sel,
    output logic [AW-1:0] cur_addr,
    output logic [1:0]    beat
);
    localparam int unsigned HI_W = AW - LOW_W;

    logic             load;
    logic [HI_W-1:0]  base_hi;
    logic [LOW_W-1:0] base_lo;
    logic [LOW_W-1:0] cur_lo;
    order_e           order_q;

    // Either strobe starts a burst.
    assign load = start_cpu | start_ctl;

    bsq_load_reg #(.AW(AW)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ext_addr (ext_addr),
        .order_in (order_e'(order_sel)),
        .base_hi  (base_hi),
        .base_lo  (base_lo),
        .order_q  (order_q)
    );

    bsq_beat_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .beat  (beat)
    );

    bsq_order_map u_map (
        .base_lo (base_lo),
        .beat    (beat),
        .order_q (order_q),
        .cur_lo  (cur_lo)
    );

    // Join the fixed upper bits and the sequenced low bits.
    assign cur_addr = {base_hi, cur_lo};

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu || start_ctl) |=> (cur_addr == $past(ext_addr) && beat == 2'd0));
    // R4
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv) |=> (beat == $past(beat) + 2'd1));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(cur_addr) && $stable(beat)));
    // R5
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && order_q == ORD_LINEAR)
            |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));
    // R6
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && order_q == ORD_INTERLEAVE)
            |=> ((cur_addr[1:0] ^ $past(cur_addr[1:0])) == (beat ^ $past(beat))));
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
// Bench: random and directed stimulus against a reference model built from
// the requirements.
module burst_addr_seq_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          start_cpu = 1'b0;
    logic          start_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [1:0]    beat;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_lo = '0;
    logic          m_ilv = 1'b0;
    logic [1:0]    m_beat = '0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .start_cpu(start_cpu), .start_ctl(start_ctl), .adv(adv),
        .order_sel(order_sel), .cur_addr(cur_addr), .beat(beat)
    );

    function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] b, logic ilv);
        return ilv ? (s ^ b) : 2'(s + b);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_hi, exp_lo(m_lo, m_beat, m_ilv)};
    endfunction

    // Apply one cycle: drive on the falling edge, update the model at the
    // rising edge, compare just after it.
    task automatic cyc(input logic r, input logic [AW-1:0] a, input logic sc,
                       input logic sk, input logic ad, input logic o,
                       input string tag);
        @(negedge clk);
        rst_n = r; ext_addr = a; start_cpu = sc; start_ctl = sk;
        adv = ad; order_sel = o;
        @(posedge clk);
        if (!r) begin
            m_hi = '0; m_lo = '0; m_ilv = 1'b0; m_beat = '0;
        end else if (sc || sk) begin
            m_hi = a[AW-1:2]; m_lo = a[1:0]; m_ilv = o; m_beat = '0;
        end else if (ad) begin
            m_beat = m_beat + 2'd1;
        end
        #1;
        n_vec++;
        if (cur_addr !== exp_addr() || beat !== m_beat) begin
            n_bad++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, cur_addr, beat, exp_addr(), m_beat);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        // R1: reset state
        repeat (3) cyc(1'b0, 20'hABCDE, 1'b1, 1'b0, 1'b1, 1'b1, "R1 reset");
        // R2: processor strobe load, linear burst past wrap (R5, R8)
        cyc(1'b1, 20'h12346, 1'b1, 1'b0, 1'b0, 1'b0, "R2 load cpu");
        repeat (6) cyc(1'b1, 20'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 R8 linear wrap");
        // R2: controller strobe load, interleaved burst (R6)
        cyc(1'b1, 20'hF00F1, 1'b0, 1'b1, 1'b0, 1'b1, "R2 load ctl");
        repeat (5) cyc(1'b1, 20'h0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 interleave");
        // R6: mode change mid-burst has no effect
        repeat (3) cyc(1'b1, 20'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 mode ignored");
        // R7: hold
        repeat (3) cyc(1'b1, 20'h55555, 1'b0, 1'b0, 1'b0, 1'b1, "R7 hold");
        // R3: start with advance
        cyc(1'b1, 20'h00003, 1'b1, 1'b1, 1'b1, 1'b0, "R3 start wins");
        // R9: back-to-back loads
        for (int i = 0; i < 4; i++)
            cyc(1'b1, 20'(32'h10000 + i * 32'h1111), i[0], !i[0], 1'b1, i[1], "R9 back-to-back");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned p = $urandom % 100;
            logic st = (p < 20);
            cyc((($urandom % 200) != 0), 20'($urandom),
                st && ($urandom % 2 == 0), st && ($urandom % 3 != 0),
                ($urandom % 100) < 65, 1'($urandom), "R2 R4 R5 R6 R7 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule